// File: doc/BRIEF.md
# Deflection Control Register Port

This block is the two-wire serial slave that holds the sixteen control bytes of a monitor deflection controller and returns one live status byte to the host. The serial clock and data lines are oversampled by a fast system clock. Each line passes through a two-flop synchronizer and a persistence filter. Start, stop and clock-edge events are taken from the filtered levels. The block only pulls the data line low: the `sdaOe` output drives an open-drain pad.

A write names the device, then one sub-address byte, then any number of data bytes. Each data byte lands in the register that the sub-address counter points at, and the counter then steps by one. A host can therefore reload the whole map in one burst. A read names the device and at once receives one status byte, with no sub-address phase. That byte is built from the lock, fault and sync-detection inputs at the moment it is loaded.

All sixteen registers appear in parallel on `regsFlat`. A write to sub-address 0x00 with bit 6 set does not store that bit. It produces a one-cycle `faultClr` pulse for the external fault latch instead.

Top module: `defl_i2c_regfile`

## Requirements
- R1: An address byte of 0x8C (write) or 0x8D (read) is acknowledged by pulling SDA low during the ninth clock. Any other address byte is not acknowledged, and the following bytes of that transaction get no acknowledge and change no register.
- R2: In a write, the byte after the address is the sub-address. A value from 0x00 to 0x0F is acknowledged and loaded into the sub-address counter. A value above 0x0F is not acknowledged, and no register changes until the next start.
- R3: Each data byte of a write is acknowledged and stored in register[counter] (bits [8k+7:8k] of `regsFlat` for register k). The counter then increments and wraps from 0x0F to 0x00.
- R4: A read returns exactly one byte, MSB first, with SDA changed only after SCL falls. After that byte SDA stays released even if the host acknowledges.
- R5: Status byte layout: bit 7 = `hUnlock` (0 means locked), bit 6 = `vUnlock` (0 means locked), bit 5 = `faultActive` (1 means fault latched), bits 4:0 = `syncFlags[4:0]`. The inputs are sampled when the byte is loaded, at the SCL fall that ends the address acknowledge.
- R6: A stop ends any transaction and releases SDA. A repeated start abandons the current transaction and begins a new address phase.
- R7: A pulse on SCL or SDA shorter than FILTER_CYC system clocks (default 5) is ignored.
- R8: Reset values: register 0x00 = 0x80 (drive on, duty code 0 = widest duty), 0x02 = 0x00 (forced frequency off), 0x03 = 0x80 (separate-sync priority), 0x05 = 0xC0 (ramp on, mid amplitude), 0x0C = 0x00. Registers 0x09, 0x0B, 0x0D and 0x0E = 0xC0. All others = 0x40. `sdaOe` and `faultClr` are 0.
- R9: A data byte written to sub-address 0x00 with bit 6 = 1 makes `faultClr` high for exactly one system clock. Bit 6 of register 0x00 is stored as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaOe | output | 1 | 1 pulls the data line low |
| hUnlock | input | 1 | Horizontal loop unlocked |
| vUnlock | input | 1 | Vertical section unlocked |
| faultActive | input | 1 | Fault latch is set |
| syncFlags | input | 5 | Sync polarity and presence flags |
| regsFlat | output | 128 | All sixteen control registers, register k in bits [8k+7:8k] |
| faultClr | output | 1 | One-cycle clear pulse for the fault latch |

## Verification
The assertions assume that SCL and SDA never change within the same few system clocks, except during a start or stop. They also assume that every level on the bus lasts longer than the filter window, so each filtered edge maps to exactly one bus event. The stimulus holds every phase of the bus clock for 25 system clocks and moves SDA only in the middle of the SCL low phase, except for deliberate start and stop edges. Deliberate glitches last two clocks, well under the filter length, so they never reach the event logic.

// File: rtl/defl_i2c_pkg.sv
package defl_i2c_pkg;

  localparam int REG_COUNT    = 16;
  localparam int SUB_BITS     = 4;
  localparam int CLR_BIT      = 6;

  typedef struct packed {
    logic shiftIn;
    logic loadStatus;
    logic shiftOut;
    logic setSub;
    logic writeData;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_SUB, ST_DATA, ST_ACK, ST_TX, ST_MACK, ST_SKIP
  } busState_t;

  typedef enum logic [1:0] {AF_SUB, AF_DATA, AF_TX} afterAck_t;

  function automatic logic [7:0] resetValue(input int idx);
    case (idx)
      0, 3:              return 8'h80;
      2, 12:             return 8'h00;
      5, 9, 11, 13, 14:  return 8'hC0;
      default:           return 8'h40;
    endcase
  endfunction

endpackage

// File: rtl/defl_i2c_sync.sv
module defl_i2c_sync #(
  parameter int FILTER_CYC = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);
  localparam int CW = $clog2(FILTER_CYC + 1);

  logic [1:0] rawIn;
  logic [1:0] lvl;
  logic [1:0] lvlPrev;

  assign rawIn = {sdaIn, sclIn};

  generate
    for (genvar g = 0; g < 2; g++) begin : gLine
      logic [1:0]    syncQ;
      logic [CW-1:0] cnt;
      logic          filt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncQ <= 2'b11;
          cnt   <= '0;
          filt  <= 1'b1;
        end else begin
          syncQ <= {syncQ[0], rawIn[g]};
          if (syncQ[1] != filt) begin
            if (cnt == CW'(FILTER_CYC - 1)) begin
              filt <= syncQ[1];
              cnt  <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else begin
            cnt <= '0;
          end
        end
      end
      assign lvl[g] = filt;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lvlPrev <= 2'b11;
    else       lvlPrev <= lvl;
  end

  assign sdaLvl  = lvl[1];
  assign sclRise = lvl[0] & ~lvlPrev[0];
  assign sclFall = ~lvl[0] & lvlPrev[0];
  assign startEv = lvl[0] & lvlPrev[0] & ~lvl[1] & lvlPrev[1];
  assign stopEv  = lvl[0] & lvlPrev[0] & lvl[1] & ~lvlPrev[1];
endmodule

// File: rtl/defl_i2c_ctrl.sv
module defl_i2c_ctrl
  import defl_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h46
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  output dpStrobe_t  strb,
  output logic       sdaOe
);
  busState_t  state, stateN;
  afterAck_t  afterAck, afterAckN;
  logic [3:0] bitCnt, bitCntN;

  always_comb begin
    stateN    = state;
    afterAckN = afterAck;
    bitCntN   = bitCnt;
    strb      = '0;
    if (stopEv) begin
      stateN = ST_IDLE;
    end else if (startEv) begin
      stateN  = ST_ADDR;
      bitCntN = '0;
    end else begin
      case (state)
        ST_ADDR, ST_SUB, ST_DATA: begin
          if (sclRise && bitCnt != 4'd8) begin
            strb.shiftIn = 1'b1;
            bitCntN      = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            bitCntN = '0;
            if (state == ST_ADDR) begin
              if (rxByte[7:1] == DEV_ADDR) begin
                stateN    = ST_ACK;
                afterAckN = rxByte[0] ? AF_TX : AF_SUB;
              end else begin
                stateN = ST_SKIP;
              end
            end else if (state == ST_SUB) begin
              if (rxByte[7:4] == 4'h0) begin
                strb.setSub = 1'b1;
                stateN      = ST_ACK;
                afterAckN   = AF_DATA;
              end else begin
                stateN = ST_SKIP;
              end
            end else begin
              strb.writeData = 1'b1;
              stateN         = ST_ACK;
              afterAckN      = AF_DATA;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            case (afterAck)
              AF_SUB:  stateN = ST_SUB;
              AF_TX: begin
                stateN          = ST_TX;
                strb.loadStatus = 1'b1;
              end
              default: stateN = ST_DATA;
            endcase
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              stateN  = ST_MACK;
              bitCntN = '0;
            end else begin
              strb.shiftOut = 1'b1;
              bitCntN       = bitCnt + 4'd1;
            end
          end
        end
        ST_MACK: if (sclFall) stateN = ST_SKIP;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      afterAck <= AF_SUB;
      bitCnt   <= '0;
    end else begin
      state    <= stateN;
      afterAck <= afterAckN;
      bitCnt   <= bitCntN;
    end
  end

  assign sdaOe = (state == ST_ACK) | ((state == ST_TX) & ~txMsb);
endmodule

// File: rtl/defl_i2c_data.sv
module defl_i2c_data
  import defl_i2c_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobe_t                strb,
  input  logic                     sdaBit,
  input  logic [7:0]               statusIn,
  output logic [7:0]               rxByte,
  output logic                     txMsb,
  output logic [SUB_BITS-1:0]      subAddr,
  output logic [REG_COUNT*8-1:0]   regsFlat,
  output logic                     faultClr
);
  logic [7:0] rxShift;
  logic [7:0] txShift;
  logic       hitZero;

  assign hitZero = (subAddr == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      txShift  <= '0;
      subAddr  <= '0;
      faultClr <= 1'b0;
    end else begin
      faultClr <= strb.writeData & hitZero & rxShift[CLR_BIT];
      if (strb.shiftIn)    rxShift <= {rxShift[6:0], sdaBit};
      if (strb.loadStatus) txShift <= statusIn;
      else if (strb.shiftOut) txShift <= {txShift[6:0], 1'b0};
      if (strb.setSub)     subAddr <= rxShift[SUB_BITS-1:0];
      else if (strb.writeData) subAddr <= subAddr + 1'b1;
    end
  end

  generate
    for (genvar k = 0; k < REG_COUNT; k++) begin : gReg
      logic [7:0] regQ;
      logic [7:0] wrVal;
      if (k == 0) begin : gMask
        assign wrVal = rxShift & ~(8'h01 << CLR_BIT);
      end else begin : gPlain
        assign wrVal = rxShift;
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          regQ <= resetValue(k);
        else if (strb.writeData && subAddr == SUB_BITS'(k))
          regQ <= wrVal;
      end
      assign regsFlat[k*8 +: 8] = regQ;
    end
  endgenerate

  assign rxByte = rxShift;
  assign txMsb  = txShift[7];
endmodule

// File: rtl/defl_i2c_regfile.sv
module defl_i2c_regfile
  import defl_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h46,
  parameter int         FILTER_CYC = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclIn,
  input  logic         sdaIn,
  output logic         sdaOe,
  input  logic         hUnlock,
  input  logic         vUnlock,
  input  logic         faultActive,
  input  logic [4:0]   syncFlags,
  output logic [127:0] regsFlat,
  output logic         faultClr
);
  logic                sdaLvl, sclRise, sclFall, startEv, stopEv;
  logic [7:0]          rxByte;
  logic                txMsb;
  logic [SUB_BITS-1:0] subAddr;
  logic                wrStrobe;
  dpStrobe_t           strb;

  defl_i2c_sync #(.FILTER_CYC(FILTER_CYC)) syncI (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv)
  );

  defl_i2c_ctrl #(.DEV_ADDR(DEV_ADDR)) ctrlI (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .rxByte(rxByte), .txMsb(txMsb),
    .strb(strb), .sdaOe(sdaOe)
  );

  defl_i2c_data dataI (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaBit(sdaLvl),
    .statusIn({hUnlock, vUnlock, faultActive, syncFlags}),
    .rxByte(rxByte), .txMsb(txMsb), .subAddr(subAddr),
    .regsFlat(regsFlat), .faultClr(faultClr)
  );

  assign wrStrobe = strb.writeData;
endmodule

// File: rtl/defl_i2c_regfile_chk.sv
module defl_i2c_regfile_chk (
  input logic         clk,
  input logic         rstN,
  input logic         sdaOe,
  input logic         sclFall,
  input logic         startEv,
  input logic         stopEv,
  input logic         wrStrobe,
  input logic [3:0]   subAddr,
  input logic [127:0] regsFlat,
  input logic         faultClr
);
  // R6
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> !sdaOe);

  // R4
  sda_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sclFall && !startEv && !stopEv) |=> $stable(sdaOe));

  // R3
  sub_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> subAddr == $past(subAddr) + 4'd1);

  // R2
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |=> $stable(regsFlat));

  // R9
  clr_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultClr |=> !faultClr);

  // R9
  clr_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultClr |-> $past(wrStrobe));
endmodule

bind defl_i2c_regfile defl_i2c_regfile_chk chkI (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .sclFall(sclFall),
  .startEv(startEv), .stopEv(stopEv), .wrStrobe(wrStrobe),
  .subAddr(subAddr), .regsFlat(regsFlat), .faultClr(faultClr)
);

// File: tb/defl_i2c_regfile_test.sv
module defl_i2c_regfile_test;
  localparam int CLK_HALF = 5;
  localparam int Q        = 25;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         sclM = 1'b1;
  logic         sdaM = 1'b1;
  logic         sdaOe;
  logic         sdaIn;
  logic         hUnlock = 1'b0, vUnlock = 1'b0, faultActive = 1'b0;
  logic [4:0]   syncFlags = '0;
  logic [127:0] regsFlat;
  logic         faultClr;
  logic         glitchOn = 1'b0;

  int errors = 0;
  int checks = 0;
  int clrPulses = 0;
  logic [7:0] expReg [16];

  assign sdaIn = sdaM & ~sdaOe;

  always #CLK_HALF clk = ~clk;

  defl_i2c_regfile uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaIn), .sdaOe(sdaOe),
    .hUnlock(hUnlock), .vUnlock(vUnlock), .faultActive(faultActive),
    .syncFlags(syncFlags), .regsFlat(regsFlat), .faultClr(faultClr)
  );

  always @(negedge clk) if (rstN && faultClr) clrPulses++;

  function automatic logic [7:0] benchDefault(input int k);
    if (k == 0 || k == 3) return 8'h80;
    if (k == 2 || k == 12) return 8'h00;
    if (k == 5 || k == 9 || k == 11 || k == 13 || k == 14) return 8'hC0;
    return 8'h40;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pause(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startC();
    sdaM = 1'b1; pause(Q);
    sclM = 1'b1; pause(Q);
    sdaM = 1'b0; pause(Q);
    sclM = 1'b0; pause(Q);
  endtask

  task automatic stopC();
    sdaM = 1'b0; pause(Q);
    sclM = 1'b1; pause(Q);
    sdaM = 1'b1; pause(2*Q);
  endtask

  task automatic bitOut(input logic b);
    sdaM = b; pause(Q);
    sclM = 1'b1; pause(Q);
    if (glitchOn) begin
      sdaM = ~b; pause(2); sdaM = b; pause(Q-2);
    end else pause(Q);
    sclM = 1'b0; pause(10);
    if (glitchOn) begin
      sclM = 1'b1; pause(2); sclM = 1'b0; pause(Q-12);
    end else pause(Q-10);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) bitOut(v[i]);
    sdaM = 1'b1; pause(Q);
    sclM = 1'b1; pause(Q);
    ack = ~sdaIn; pause(Q);
    sclM = 1'b0; pause(Q);
  endtask

  task automatic recvByte(output logic [7:0] v, input logic hostAck);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; pause(Q);
      sclM = 1'b1; pause(Q);
      v[i] = sdaIn; pause(Q);
      sclM = 1'b0; pause(Q);
    end
    sdaM = ~hostAck; pause(Q);
    sclM = 1'b1; pause(2*Q);
    sclM = 1'b0; pause(Q);
    sdaM = 1'b1;
  endtask

  task automatic compareAll(input string req);
    for (int k = 0; k < 16; k++) chk(req, regsFlat[k*8 +: 8], expReg[k]);
  endtask

  task automatic noteWrite(input int idx, input logic [7:0] v);
    expReg[idx % 16] = (idx % 16 == 0) ? (v & 8'hBF) : v;
  endtask

  initial begin
    pause(190000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] rd;
    int pulsesBefore;
    pause(5);
    // R8 reset state
    for (int k = 0; k < 16; k++) expReg[k] = benchDefault(k);
    compareAll("R8 reset value");
    chk("R8 sdaOe reset", sdaOe, 0);
    chk("R8 faultClr reset", faultClr, 0);
    rstN = 1'b1;
    pause(10);

    // R1 R2 R3 single write
    startC();
    sendByte(8'h8C, ack); chk("R1 write address ack", ack, 1);
    sendByte(8'h05, ack); chk("R2 sub-address ack", ack, 1);
    sendByte(8'h3A, ack); chk("R3 data ack", ack, 1);
    stopC();
    noteWrite(5, 8'h3A);
    compareAll("R3 single write");
    chk("R6 released after stop", sdaOe, 0);

    // R3 wrap and R9 clear pulse
    pulsesBefore = clrPulses;
    startC();
    sendByte(8'h8C, ack); chk("R1 ack", ack, 1);
    sendByte(8'h0E, ack); chk("R2 ack", ack, 1);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] v;
      v = (i == 2) ? 8'hFF : 8'(8'h11 * (i + 1));
      sendByte(v, ack); chk("R3 burst ack", ack, 1);
      noteWrite(14 + i, v);
    end
    stopC();
    compareAll("R3 wrap burst");
    chk("R9 one clear pulse", clrPulses - pulsesBefore, 1);

    // R3 full map burst; byte0 has bit6 clear so no pulse
    pulsesBefore = clrPulses;
    startC();
    sendByte(8'h8C, ack);
    sendByte(8'h00, ack);
    for (int k = 0; k < 16; k++) begin
      logic [7:0] v;
      v = 8'(k * 37 + 5);
      sendByte(v, ack); chk("R3 full burst ack", ack, 1);
      noteWrite(k, v);
    end
    stopC();
    compareAll("R3 full burst");
    chk("R9 no pulse when bit6 clear", clrPulses - pulsesBefore, 0);

    // R1 foreign addresses ignored
    for (int j = 0; j < 4; j++) begin
      logic [7:0] a;
      case (j)
        0: a = 8'h8E;
        1: a = 8'h0C;
        2: a = 8'h9C;
        default: a = 8'h8A;
      endcase
      startC();
      sendByte(a, ack); chk("R1 foreign address nack", ack, 0);
      sendByte(8'h01, ack); chk("R1 following byte nack", ack, 0);
      sendByte(8'h55, ack); chk("R1 following byte nack", ack, 0);
      stopC();
    end
    compareAll("R1 registers unchanged");

    // R2 out-of-range sub-address
    startC();
    sendByte(8'h8C, ack); chk("R1 ack", ack, 1);
    sendByte(8'h13, ack); chk("R2 range nack", ack, 0);
    sendByte(8'h77, ack); chk("R2 data after bad sub nack", ack, 0);
    stopC();
    compareAll("R2 registers unchanged");

    // R4 R5 status read sweep
    for (int p = 0; p < 8; p++) begin
      hUnlock = p[2]; vUnlock = p[1]; faultActive = p[0];
      syncFlags = 5'((p * 5 + 3) & 31);
      startC();
      sendByte(8'h8D, ack); chk("R1 read address ack", ack, 1);
      recvByte(rd, 1'b0);
      stopC();
      chk("R5 status byte", rd, {p[2], p[1], p[0], 5'((p * 5 + 3) & 31)});
      chk("R6 released after read", sdaOe, 0);
    end

    // R4 only one byte even with host acknowledge
    hUnlock = 1'b0; vUnlock = 1'b0; faultActive = 1'b0; syncFlags = 5'h00;
    startC();
    sendByte(8'h8D, ack);
    recvByte(rd, 1'b1);
    chk("R4 first byte", rd, 8'h00);
    recvByte(rd, 1'b0);
    chk("R4 no second byte", rd, 8'hFF);
    stopC();

    // R6 repeated start turns a write into a read
    hUnlock = 1'b1; syncFlags = 5'h0A;
    startC();
    sendByte(8'h8C, ack);
    sendByte(8'h02, ack);
    sendByte(8'h12, ack); chk("R3 ack before restart", ack, 1);
    noteWrite(2, 8'h12);
    startC();
    sendByte(8'h8D, ack); chk("R6 read after restart ack", ack, 1);
    recvByte(rd, 1'b0);
    stopC();
    chk("R6 status after restart", rd, 8'h8A);
    compareAll("R6 write before restart kept");

    // R7 short glitches on both lines during a data byte
    startC();
    sendByte(8'h8C, ack);
    sendByte(8'h0A, ack);
    glitchOn = 1'b1;
    sendByte(8'h5C, ack);
    glitchOn = 1'b0;
    chk("R7 ack with glitches", ack, 1);
    stopC();
    noteWrite(10, 8'h5C);
    compareAll("R7 glitches ignored");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule